// File: doc/BRIEF.md
# RAID P/Q Parity Engine

This block computes RAID parity over a group of equal-length source blocks that arrive one after another as byte streams. For every byte position it forms two results. P is the plain XOR of all sources. Q is a Galois-field GF(2^8) weighted sum, in which each source byte is multiplied by that source's own 8-bit coefficient before the XOR. The reduction polynomial comes from a configuration input. A command selects P-only, Q-only or dual output. It gives the source count minus one, the coefficients, the block length and a continuation flag. When the continuation flag is set, the old destination contents are streamed back in as extra weighted sources, so that a new parity can be built on top of an earlier one.

Running totals are held in an on-chip buffer, one P byte and one Q byte per byte position. The first source overwrites the buffer, and each later source is folded into it. While the final source streams in, the results come out one byte per accepted byte. A command that cannot run is refused with a one-cycle error pulse and produces no output.

Top module: `raid_pq_engine`

## Requirements
- R1: In P mode (opcode 0) every output byte `out_p` is the XOR of the sources' bytes at that position, and `out_q` equals `out_p` because every coefficient is forced to 1.
- R2: In Q mode (opcode 1) `out_q` is the XOR over the sources of coefficient times source byte. The coefficient for source i is `cmd_coef[8*i+7:8*i]`. The GF(2^8) product uses x^8 plus the 8-bit `cfg_poly` as its reduction polynomial (0x1D for the usual 0x11D).
- R3: In dual mode (opcode 2) one pass delivers both the plain XOR on `out_p` and the weighted sum on `out_q`.
- R4: The source count is given as `cmd_cnt_m1` = count minus one. A command is refused when the opcode is 3 or when the effective count falls outside 2..16. On refusal `err` pulses one cycle after the command is taken, no output follows and `cmd_ready` stays high.
- R5: A Q-mode command with a single source is accepted. It counts as two copies of the source with coefficients c and 0, so only one stream is sent and `out_q` = c times source.
- R6: A length of 0, or above LEN_LIMIT = min(1 MiB, buffer depth, 64 by default), is refused with `err`. A length equal to LEN_LIMIT is accepted.
- R7: With continuation in P or Q mode, one extra stream (index = user count) carries the old destination with Q coefficient 1. The effective count rises by one.
- R8: With continuation in dual mode, three extra streams follow the user sources: old P, old Q and old Q again. Their Q coefficients are 0, 0 and 1, and all of them enter P. The count rises by three.
- R9: `out_valid` rises exactly one cycle after each accepted byte of the final stream and at no other time. `out_last` and `done` pulse together with the output of the last byte.
- R10: A source byte whose `src_idx` differs from the expected stream number aborts the command. `err` pulses one cycle later, no output follows and the engine is ready for a new command.
- R11: After reset the engine is idle: `cmd_ready` is 1, and `src_ready`, `out_valid`, `done` and `err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_poly | input | 8 | Low 8 bits of the GF reduction polynomial |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Engine idle, command accepted |
| cmd_op | input | 2 | 0 P, 1 Q, 2 dual, 3 invalid |
| cmd_cnt_m1 | input | 5 | Source count minus one |
| cmd_cont | input | 1 | Continuation flag |
| cmd_len | input | 21 | Block length in bytes |
| cmd_coef | input | 128 | Sixteen 8-bit Q coefficients, source i at bits 8i+7:8i |
| src_valid | input | 1 | Source byte present |
| src_ready | output | 1 | Engine consuming source bytes |
| src_idx | input | 4 | Stream number of the byte |
| src_data | input | 8 | Source byte |
| out_valid | output | 1 | Result byte present |
| out_p | output | 8 | XOR result byte |
| out_q | output | 8 | Weighted result byte |
| out_last | output | 1 | Last result byte of the block |
| done | output | 1 | Command finished |
| err | output | 1 | Command refused or aborted |

## Verification
A refusal shows on `err` one clock after the edge that takes the command. A result byte shows on `out_p`/`out_q` one clock after the edge that takes the matching final-stream byte, and the last one carries `out_last` and `done`. The bench drives inputs on the falling edge and reads the outputs two nanoseconds after the rising edge that follows. So each check sees exactly the register stage that the byte or command just loaded. Every byte of a non-final stream is also checked for a quiet `out_valid`.

// File: rtl/raid_pq_pkg.sv
package raid_pq_pkg;

  typedef enum logic [1:0] {
    OP_P   = 2'd0,
    OP_Q   = 2'd1,
    OP_PQ  = 2'd2,
    OP_BAD = 2'd3
  } pq_op_e;

  // GF(2^8) product, LSB-first shift-and-add with conditional reduction.
  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b,
                                        input logic [7:0] poly);
    logic [7:0] acc;
    logic [7:0] sh;
    acc = 8'h00;
    sh  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = sh[7] ? ({sh[6:0], 1'b0} ^ poly) : {sh[6:0], 1'b0};
    end
    return acc;
  endfunction

endpackage

// File: rtl/raid_pq_cmd.sv
module raid_pq_cmd
  import raid_pq_pkg::*;
#(
  parameter int MAX_SRC   = 16,
  parameter int CNT_W     = 5,
  parameter int SIDX_W    = 4,
  parameter int LEN_W     = 21,
  parameter int LEN_LIMIT = 64
) (
  input  logic [1:0]           op,
  input  logic [CNT_W-1:0]     cnt_m1,
  input  logic                 cont,
  input  logic [LEN_W-1:0]     len,
  input  logic [MAX_SRC*8-1:0] coef_in,
  output logic                 ok,
  output logic [SIDX_W-1:0]    last_stream,
  output logic [MAX_SRC*8-1:0] coef_out
);
  localparam int EW = CNT_W + 2;

  logic [EW-1:0] n_user, n_base, n_extra, n_eff, n_streams;
  logic          len_ok, cnt_ok, op_ok;

  always_comb begin
    n_user    = EW'(cnt_m1) + EW'(1);
    n_base    = (op == OP_Q && n_user == EW'(1)) ? EW'(2) : n_user;
    n_extra   = !cont ? EW'(0) : ((op == OP_PQ) ? EW'(3) : EW'(1));
    n_eff     = n_base + n_extra;
    n_streams = n_user + n_extra;
    len_ok    = (len != '0) && (len <= LEN_W'(LEN_LIMIT));
    cnt_ok    = (n_eff >= EW'(2)) && (n_eff <= EW'(MAX_SRC));
    op_ok     = (op != OP_BAD);
    ok        = len_ok && cnt_ok && op_ok;
    last_stream = SIDX_W'(n_streams - EW'(1));
  end

  for (genvar g = 0; g < MAX_SRC; g++) begin : g_coef
    logic [7:0] c;
    always_comb begin
      if (op == OP_P)                 c = 8'h01;
      else if (EW'(g) < n_user)       c = coef_in[g*8 +: 8];
      else if (op == OP_PQ)           c = (EW'(g) == n_user + EW'(2)) ? 8'h01 : 8'h00;
      else                            c = 8'h01;
    end
    assign coef_out[g*8 +: 8] = c;
  end

endmodule

// File: rtl/raid_pq_gfmul.sv
module raid_pq_gfmul
  import raid_pq_pkg::*;
(
  input  logic [7:0] a,
  input  logic [7:0] b,
  input  logic [7:0] poly,
  output logic [7:0] y
);
  assign y = gf_mul(a, b, poly);
endmodule

// File: rtl/raid_pq_acc.sv
module raid_pq_acc #(
  parameter int DEPTH = 64,
  parameter int AW    = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          first,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    p_term,
  input  logic [7:0]    q_term,
  output logic [7:0]    p_sum,
  output logic [7:0]    q_sum
);
  logic [7:0] p_mem [DEPTH];
  logic [7:0] q_mem [DEPTH];
  logic       seeded;

  assign p_sum = first ? p_term : (p_mem[addr] ^ p_term);
  assign q_sum = first ? q_term : (q_mem[addr] ^ q_term);

  always_ff @(posedge clk) begin
    if (wr_en) begin
      p_mem[addr] <= p_sum;
      q_mem[addr] <= q_sum;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                seeded <= 1'b0;
    else if (wr_en && first)   seeded <= 1'b1;
  end

  AST_FOLD_AFTER_SEED: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && !first) |-> seeded); // R1
endmodule

// File: rtl/raid_pq_engine.sv
module raid_pq_engine
  import raid_pq_pkg::*;
#(
  parameter int MAX_SRC = 16,
  parameter int DEPTH   = 64,
  parameter int MAX_LEN = 1048576,
  parameter int LEN_W   = 21
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [7:0]                        cfg_poly,
  input  logic                              cmd_valid,
  output logic                              cmd_ready,
  input  logic [1:0]                        cmd_op,
  input  logic [$clog2(MAX_SRC):0]          cmd_cnt_m1,
  input  logic                              cmd_cont,
  input  logic [LEN_W-1:0]                  cmd_len,
  input  logic [MAX_SRC*8-1:0]              cmd_coef,
  input  logic                              src_valid,
  output logic                              src_ready,
  input  logic [$clog2(MAX_SRC)-1:0]        src_idx,
  input  logic [7:0]                        src_data,
  output logic                              out_valid,
  output logic [7:0]                        out_p,
  output logic [7:0]                        out_q,
  output logic                              out_last,
  output logic                              done,
  output logic                              err
);
  localparam int SIDX_W    = $clog2(MAX_SRC);
  localparam int CNT_W     = SIDX_W + 1;
  localparam int AW        = $clog2(DEPTH);
  localparam int LEN_LIMIT = (MAX_LEN < DEPTH) ? MAX_LEN : DEPTH;

  // command decode
  logic                 dec_ok;
  logic [SIDX_W-1:0]    dec_last;
  logic [MAX_SRC*8-1:0] dec_coef;

  raid_pq_cmd #(
    .MAX_SRC(MAX_SRC), .CNT_W(CNT_W), .SIDX_W(SIDX_W),
    .LEN_W(LEN_W), .LEN_LIMIT(LEN_LIMIT)
  ) u_cmd (
    .op(cmd_op), .cnt_m1(cmd_cnt_m1), .cont(cmd_cont), .len(cmd_len),
    .coef_in(cmd_coef), .ok(dec_ok), .last_stream(dec_last), .coef_out(dec_coef)
  );

  // job state
  logic              busy;
  logic [1:0]        op_r;
  logic [SIDX_W-1:0] cur_stream, last_stream;
  logic [AW-1:0]     byte_cnt, len_m1;
  logic [7:0]        coef_r [MAX_SRC];

  // named events
  logic cmd_fire, cmd_take, cmd_reject;
  logic byte_fire, idx_bad, byte_take, end_of_stream, final_stream, final_byte;

  assign cmd_ready     = !busy;
  assign src_ready     = busy;
  assign cmd_fire      = cmd_valid && cmd_ready;
  assign cmd_take      = cmd_fire && dec_ok;
  assign cmd_reject    = cmd_fire && !dec_ok;
  assign byte_fire     = src_valid && src_ready;
  assign idx_bad       = byte_fire && (src_idx != cur_stream);
  assign byte_take     = byte_fire && !idx_bad;
  assign end_of_stream = byte_take && (byte_cnt == len_m1);
  assign final_stream  = (cur_stream == last_stream);
  assign final_byte    = end_of_stream && final_stream;

  // datapath
  logic [7:0] q_term, p_sum, q_sum;

  raid_pq_gfmul u_mul (
    .a(src_data), .b(coef_r[cur_stream]), .poly(cfg_poly), .y(q_term)
  );

  raid_pq_acc #(.DEPTH(DEPTH), .AW(AW)) u_acc (
    .clk(clk), .rst_n(rst_n), .wr_en(byte_take), .first(cur_stream == '0),
    .addr(byte_cnt), .p_term(src_data), .q_term(q_term),
    .p_sum(p_sum), .q_sum(q_sum)
  );

  for (genvar g = 0; g < MAX_SRC; g++) begin : g_coef_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        coef_r[g] <= 8'h00;
      else if (cmd_take) coef_r[g] <= dec_coef[g*8 +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy        <= 1'b0;
      op_r        <= OP_P;
      cur_stream  <= '0;
      last_stream <= '0;
      byte_cnt    <= '0;
      len_m1      <= '0;
    end else if (cmd_take) begin
      busy        <= 1'b1;
      op_r        <= cmd_op;
      cur_stream  <= '0;
      last_stream <= dec_last;
      byte_cnt    <= '0;
      len_m1      <= AW'(cmd_len - LEN_W'(1));
    end else if (idx_bad) begin
      busy <= 1'b0;
    end else if (byte_take) begin
      if (end_of_stream) begin
        byte_cnt <= '0;
        if (final_stream) busy <= 1'b0;
        else              cur_stream <= cur_stream + SIDX_W'(1);
      end else begin
        byte_cnt <= byte_cnt + AW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_p     <= 8'h00;
      out_q     <= 8'h00;
      out_last  <= 1'b0;
      done      <= 1'b0;
      err       <= 1'b0;
    end else begin
      out_valid <= byte_take && final_stream;
      out_p     <= p_sum;
      out_q     <= q_sum;
      out_last  <= final_byte;
      done      <= final_byte;
      err       <= cmd_reject || idx_bad;
    end
  end

  AST_DONE_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n) done |-> (out_valid && out_last)); // R9
  AST_OUT_FROM_BUSY: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> $past(busy)); // R9
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n) err |-> (!busy && !out_valid)); // R4
  AST_ERR_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n) !(err && done)); // R10
  AST_START_ON_CMD: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(cmd_valid)); // R4
  AST_P_MODE_EQUAL: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && op_r == OP_P) |-> (out_p == out_q)); // R1
endmodule

// File: tb/raid_pq_engine_bench.sv
module raid_pq_engine_bench;
  logic         clk, rst_n;
  logic [7:0]   cfg_poly;
  logic         cmd_valid, cmd_ready, cmd_cont;
  logic [1:0]   cmd_op;
  logic [4:0]   cmd_cnt_m1;
  logic [20:0]  cmd_len;
  logic [127:0] cmd_coef;
  logic         src_valid, src_ready;
  logic [3:0]   src_idx;
  logic [7:0]   src_data;
  logic         out_valid, out_last, done, err;
  logic [7:0]   out_p, out_q;

  raid_pq_engine u_raid_pq_engine (
    .clk(clk), .rst_n(rst_n), .cfg_poly(cfg_poly),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_cnt_m1(cmd_cnt_m1), .cmd_cont(cmd_cont), .cmd_len(cmd_len),
    .cmd_coef(cmd_coef), .src_valid(src_valid), .src_ready(src_ready),
    .src_idx(src_idx), .src_data(src_data), .out_valid(out_valid),
    .out_p(out_p), .out_q(out_q), .out_last(out_last), .done(done), .err(err)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [7:0] sd [16][64];
  logic [7:0] cf [16];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // MSB-first Horner form of the GF(2^8) product
  function automatic logic [7:0] gref(input logic [7:0] a, input logic [7:0] b,
                                      input logic [7:0] poly);
    logic [7:0] r;
    r = 8'h00;
    for (int i = 7; i >= 0; i--) begin
      r = {r[6:0], 1'b0} ^ (r[7] ? poly : 8'h00);
      if (b[i]) r = r ^ a;
    end
    return r;
  endfunction

  task automatic fill(input int seed);
    for (int s = 0; s < 16; s++) begin
      for (int k = 0; k < 64; k++)
        sd[s][k] = 8'((s * 53 + k * 29 + seed * 97) ^ (k * k) ^ (seed >> 2));
      cf[s] = 8'(s * 71 + seed * 13 + 5);
    end
  endtask

  task automatic run_job(input int op, input int n, input bit cont,
                         input int len, input string req);
    int extra, streams;
    logic [7:0] ep [64];
    logic [7:0] eq [64];
    logic [7:0] qc;
    extra = cont ? ((op == 2) ? 3 : 1) : 0;
    streams = n + extra;
    for (int k = 0; k < len; k++) begin
      ep[k] = 8'h00;
      eq[k] = 8'h00;
      for (int s = 0; s < streams; s++) begin
        if (op == 0)      qc = 8'h01;
        else if (s < n)   qc = cf[s];
        else if (op == 2) qc = (s == n + 2) ? 8'h01 : 8'h00;
        else              qc = 8'h01;
        ep[k] = ep[k] ^ sd[s][k];
        eq[k] = eq[k] ^ gref(sd[s][k], qc, cfg_poly);
      end
    end
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op = 2'(op);
    cmd_cnt_m1 = 5'(n - 1);
    cmd_cont = cont;
    cmd_len = 21'(len);
    for (int i = 0; i < 16; i++) cmd_coef[i*8 +: 8] = cf[i];
    @(posedge clk); #2;
    chk(err == 1'b0 && src_ready == 1'b1, req, "accept", int'(err), 0);
    @(negedge clk);
    cmd_valid = 1'b0;
    for (int s = 0; s < streams; s++) begin
      for (int k = 0; k < len; k++) begin
        src_valid = 1'b1;
        src_idx = 4'(s);
        src_data = sd[s][k];
        @(posedge clk); #2;
        if (s == streams - 1) begin
          chk(out_valid == 1'b1, "R9", "out_valid", int'(out_valid), 1);
          chk(out_p == ep[k], req, "out_p", int'(out_p), int'(ep[k]));
          chk(out_q == eq[k], req, "out_q", int'(out_q), int'(eq[k]));
          chk(out_last == (k == len - 1), "R9", "out_last", int'(out_last), int'(k == len - 1));
          chk(done == (k == len - 1), "R9", "done", int'(done), int'(k == len - 1));
        end else begin
          chk(out_valid == 1'b0, "R9", "early out_valid", int'(out_valid), 0);
        end
        @(negedge clk);
      end
    end
    src_valid = 1'b0;
    @(posedge clk); #2;
    chk(out_valid == 1'b0 && cmd_ready == 1'b1, "R9", "idle after job", int'(out_valid), 0);
  endtask

  task automatic rej(input int op, input int n_m1, input bit cont,
                     input int len, input string req);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op = 2'(op);
    cmd_cnt_m1 = 5'(n_m1);
    cmd_cont = cont;
    cmd_len = 21'(len);
    @(posedge clk); #2;
    chk(err == 1'b1 && out_valid == 1'b0, req, "refusal err", int'(err), 1);
    chk(cmd_ready == 1'b1 && src_ready == 1'b0, req, "still idle", int'(cmd_ready), 1);
    @(negedge clk);
    cmd_valid = 1'b0;
    @(posedge clk); #2;
    chk(err == 1'b0 && out_valid == 1'b0, req, "err one cycle", int'(err), 0);
  endtask

  initial begin
    rst_n = 1'b0;
    cfg_poly = 8'h1D;
    cmd_valid = 1'b0; cmd_op = 2'd0; cmd_cnt_m1 = '0; cmd_cont = 1'b0;
    cmd_len = '0; cmd_coef = '0;
    src_valid = 1'b0; src_idx = '0; src_data = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #2;
    chk(cmd_ready && !src_ready && !out_valid && !done && !err, "R11", "reset state",
        int'({cmd_ready, src_ready, out_valid, done, err}), 5'b10000);

    for (int n = 2; n <= 16; n++) begin fill(n); run_job(0, n, 1'b0, 8, "R1"); end
    for (int n = 2; n <= 16; n++) begin fill(n + 20); run_job(1, n, 1'b0, 8, "R2"); end
    cfg_poly = 8'h2B;
    fill(7); run_job(1, 5, 1'b0, 12, "R2");
    cfg_poly = 8'h1D;
    for (int n = 2; n <= 16; n++) begin fill(n + 40); run_job(2, n, 1'b0, 8, "R3"); end

    for (int c = 0; c < 256; c++) begin
      fill(c);
      cf[0] = 8'(c);
      for (int k = 0; k < 16; k++) sd[0][k] = 8'(c * 16 + k);
      run_job(1, 1, 1'b0, 16, "R5");
    end

    fill(3); run_job(1, 3, 1'b1, 8, "R7");
    fill(4); run_job(0, 1, 1'b1, 8, "R7");
    fill(5); run_job(1, 15, 1'b1, 4, "R7");
    for (int n = 2; n <= 13; n++) begin fill(n + 60); run_job(2, n, 1'b1, 6, "R8"); end

    rej(0, 0, 1'b0, 8, "R4");
    rej(2, 16, 1'b0, 8, "R4");
    rej(2, 13, 1'b1, 8, "R4");
    rej(1, 15, 1'b1, 8, "R4");
    rej(3, 3, 1'b0, 8, "R4");
    rej(0, 3, 1'b0, 0, "R6");
    rej(0, 3, 1'b0, 65, "R6");
    rej(2, 3, 1'b0, 1048577, "R6");
    fill(9); run_job(2, 3, 1'b0, 64, "R6");

    // R10: wrong stream number mid-command
    fill(11);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'd0; cmd_cnt_m1 = 5'd2; cmd_cont = 1'b0; cmd_len = 21'd4;
    @(negedge clk);
    cmd_valid = 1'b0;
    for (int k = 0; k < 4; k++) begin
      src_valid = 1'b1; src_idx = 4'd0; src_data = sd[0][k];
      @(negedge clk);
    end
    src_idx = 4'd2; src_data = 8'h55;
    @(posedge clk); #2;
    chk(err == 1'b1 && out_valid == 1'b0, "R10", "abort err", int'(err), 1);
    chk(cmd_ready == 1'b1 && src_ready == 1'b0, "R10", "back to idle", int'(cmd_ready), 1);
    @(negedge clk);
    src_valid = 1'b0;
    @(posedge clk); #2;
    chk(out_valid == 1'b0 && done == 1'b0, "R10", "no output", int'(out_valid), 0);
    fill(12); run_job(0, 2, 1'b0, 4, "R10");

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog run did not finish actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule